// File: doc/BRIEF.md
# Compare-Driven Output Set/Clear/Toggle Unit

This block holds three compare values and checks each one against an external free-running timer whenever that timer advances. A hit on the first compare value drives selected low bits of an 8-bit output port high. A hit on the second drives selected low bits low. A hit on the third flips the two high bits. Each hit also raises a sticky interrupt flag.

Two enable masks choose which port bits each hit may touch. The toggle action does not read the port latch. Each high bit has a hidden "next toggle value" flip-flop, and the port bit copies that flip-flop. Software can write the port directly through the register port. Fixed rules settle collisions: a hardware action on a bit beats a software write to that bit in the same cycle, and a clear beats a set.

The register port decodes a 3-bit address:

| Address | Register |
|---|---|
| 0 | compare value 0 |
| 1 | compare value 1 |
| 2 | compare value 2 |
| 3 | set-enable register |
| 4 | clear/toggle-enable register |
| 5 | port |
| 6 | flags |

Reads come back combinationally on `reg_rdata_o`, zero-extended.

Top module: `cmp_port_unit`

## Requirements
- R1: A compare value hits only in a cycle where `tick_i` is 1 and `timer_i` equals that value. When `tick_i` is 0, an equal timer value has no effect.
- R2: `flag_o[i]` becomes 1 on the second rising edge after the hit cycle of compare value i. Writing a 1 to bit i at address 6 clears it, and a set in the same cycle beats the clear. Address 6 reads the flags in bits 2:0.
- R3: A hit on compare value 0 drives port bits 5:0 to 1 wherever the matching bit of the set-enable register (address 3, bits 5:0) is 1.
- R4: A hit on compare value 1 drives port bits 5:0 to 0 wherever the matching bit of the clear/toggle-enable register (address 4) is 1. Bits whose enable is 0 keep their value.
- R5: A hit on compare value 2 acts on each of port bits 7:6 whose clear/toggle-enable bit is 1. The port bit takes the value of its toggle-state flip-flop, and that flip-flop then inverts.
- R6: The toggle-state flip-flops for port bits 7 and 6 read back at address 3, bits 7 and 6. They reset to 1, so the first toggle after reset sets the bit. Writes to those two bits are ignored.
- R7: Reset clears all three compare values, both enable registers, the port and the flags.
- R8: When a set and a clear hit the same low port bit in the same cycle, the bit ends up 0.
- R9: When a hardware action and a software write to address 5 land on the same port bit in the same cycle, the hardware result wins. Bits that no hardware action touches take the software value.
- R10: A hardware port change and a software port write both show on `port_o` after the first rising edge that ends the hit or write cycle.
- R11: Software writes to the port do not change the toggle-state flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advance strobe; `timer_i` holds the new value |
| timer_i | input | 16 | Current timer value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| port_o | output | 8 | Output port latch |
| flag_o | output | 3 | Sticky hit flags, one for each compare value |

## Verification
The bench builds the block with its default parameters: a 16-bit timer, an 8-bit port, six set/clear bits and two toggle bits. These defaults make both enable masks, the toggle-state readback at address 3 and the full compare width reachable.

Compare values stay small so each hit takes a single tick. The flag pipeline and the port update are sampled at their exact edges. Collisions are set up deliberately:
- set against clear on the same bit;
- a hardware action against a software write in the same cycle;
- a software write against the hidden toggle state.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int NUM_CMP = 3;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CMP0 = 3'd0,
    RA_CMP1 = 3'd1,
    RA_CMP2 = 3'd2,
    RA_SEN  = 3'd3,
    RA_CTEN = 3'd4,
    RA_PORT = 3'd5,
    RA_FLAG = 3'd6
  } reg_addr_e;

  typedef enum int {
    CH_SET = 0,
    CH_CLR = 1,
    CH_TGL = 2
  } cmp_ch_e;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PORT_W = 8,
  parameter int TGL_W  = 2,
  localparam int SR_W  = PORT_W - TGL_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [TMR_W-1:0]               wdata_i,
  input  logic [TGL_W-1:0]               tgl_i,
  input  logic [PORT_W-1:0]              port_i,
  input  logic [NUM_CMP-1:0]             flag_i,
  output logic [NUM_CMP-1:0][TMR_W-1:0]  cmp_o,
  output logic [SR_W-1:0]                set_en_o,
  output logic [PORT_W-1:0]              ct_en_o,
  output logic                           port_we_o,
  output logic [PORT_W-1:0]              port_wd_o,
  output logic [NUM_CMP-1:0]             flag_clr_o,
  output logic [TMR_W-1:0]               rdata_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cmp_o[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i)) cmp_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_en_o <= '0;
      ct_en_o  <= '0;
    end else if (we_i) begin
      if (addr == RA_SEN)  set_en_o <= wdata_i[SR_W-1:0];
      if (addr == RA_CTEN) ct_en_o  <= wdata_i[PORT_W-1:0];
    end
  end

  assign port_we_o  = we_i && (addr == RA_PORT);
  assign port_wd_o  = wdata_i[PORT_W-1:0];
  assign flag_clr_o = (we_i && addr == RA_FLAG) ? wdata_i[NUM_CMP-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      RA_CMP0: rdata_o = cmp_o[0];
      RA_CMP1: rdata_o = cmp_o[1];
      RA_CMP2: rdata_o = cmp_o[2];
      RA_SEN:  rdata_o = TMR_W'({tgl_i, set_en_o});
      RA_CTEN: rdata_o = TMR_W'(ct_en_o);
      RA_PORT: rdata_o = TMR_W'(port_i);
      RA_FLAG: rdata_o = TMR_W'(flag_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_match.sv
module cmp_match
  import cmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [TMR_W-1:0]              timer_i,
  input  logic [NUM_CMP-1:0][TMR_W-1:0] cmp_i,
  input  logic [NUM_CMP-1:0]            flag_clr_i,
  output logic [NUM_CMP-1:0]            hit_o,
  output logic [NUM_CMP-1:0]            flag_o
);
  logic [NUM_CMP-1:0] hit_q;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
    assign hit_o[i] = tick_i && (timer_i == cmp_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[i]  <= 1'b0;
        flag_o[i] <= 1'b0;
      end else begin
        hit_q[i] <= hit_o[i];
        // set wins over a same-cycle clear
        if (hit_q[i])           flag_o[i] <= 1'b1;
        else if (flag_clr_i[i]) flag_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmp_port_logic.sv
module cmp_port_logic
  import cmp_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int TGL_W  = 2,
  localparam int SR_W  = PORT_W - TGL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CMP-1:0] hit_i,
  input  logic [SR_W-1:0]    set_en_i,
  input  logic [PORT_W-1:0]  ct_en_i,
  input  logic               sw_we_i,
  input  logic [PORT_W-1:0]  sw_d_i,
  output logic [PORT_W-1:0]  port_o,
  output logic [TGL_W-1:0]   tgl_o
);
  logic [SR_W-1:0]  hw_set, hw_clr;
  logic [TGL_W-1:0] hw_tgl;

  assign hw_set = {SR_W{hit_i[CH_SET]}} & set_en_i;
  assign hw_clr = {SR_W{hit_i[CH_CLR]}} & ct_en_i[SR_W-1:0];
  assign hw_tgl = {TGL_W{hit_i[CH_TGL]}} & ct_en_i[PORT_W-1:SR_W];

  for (genvar k = 0; k < SR_W; k++) begin : g_sr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        port_o[k] <= 1'b0;
      else if (hw_clr[k]) port_o[k] <= 1'b0;
      else if (hw_set[k]) port_o[k] <= 1'b1;
      else if (sw_we_i)   port_o[k] <= sw_d_i[k];
    end
  end

  for (genvar k = 0; k < TGL_W; k++) begin : g_tg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        port_o[SR_W+k] <= 1'b0;
        tgl_o[k]       <= 1'b1;
      end else if (hw_tgl[k]) begin
        port_o[SR_W+k] <= tgl_o[k];
        tgl_o[k]       <= ~tgl_o[k];
      end else if (sw_we_i) begin
        port_o[SR_W+k] <= sw_d_i[SR_W+k];
      end
    end
  end
endmodule

// File: rtl/cmp_port_unit.sv
module cmp_port_unit
  import cmp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PORT_W = 8,
  parameter int TGL_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [TMR_W-1:0]   timer_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [TMR_W-1:0]   reg_wdata_i,
  output logic [TMR_W-1:0]   reg_rdata_o,
  output logic [PORT_W-1:0]  port_o,
  output logic [NUM_CMP-1:0] flag_o
);
  localparam int SR_W = PORT_W - TGL_W;

  logic [NUM_CMP-1:0][TMR_W-1:0] cmp_val;
  logic [SR_W-1:0]               set_en;
  logic [PORT_W-1:0]             ct_en;
  logic                          port_we;
  logic [PORT_W-1:0]             port_wd;
  logic [NUM_CMP-1:0]            flag_clr;
  logic [NUM_CMP-1:0]            hit;
  logic [TGL_W-1:0]              tgl_q;

  cmp_regs #(.TMR_W(TMR_W), .PORT_W(PORT_W), .TGL_W(TGL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .tgl_i      (tgl_q),
    .port_i     (port_o),
    .flag_i     (flag_o),
    .cmp_o      (cmp_val),
    .set_en_o   (set_en),
    .ct_en_o    (ct_en),
    .port_we_o  (port_we),
    .port_wd_o  (port_wd),
    .flag_clr_o (flag_clr),
    .rdata_o    (reg_rdata_o)
  );

  cmp_match #(.TMR_W(TMR_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .timer_i    (timer_i),
    .cmp_i      (cmp_val),
    .flag_clr_i (flag_clr),
    .hit_o      (hit),
    .flag_o     (flag_o)
  );

  cmp_port_logic #(.PORT_W(PORT_W), .TGL_W(TGL_W)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .set_en_i (set_en),
    .ct_en_i  (ct_en),
    .sw_we_i  (port_we),
    .sw_d_i   (port_wd),
    .port_o   (port_o),
    .tgl_o    (tgl_q)
  );
endmodule

// File: rtl/cmp_port_chk.sv
module cmp_port_chk
  import cmp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PORT_W = 8,
  parameter int TGL_W  = 2,
  localparam int SR_W  = PORT_W - TGL_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          tick_i,
  input logic [TMR_W-1:0]              timer_i,
  input logic [NUM_CMP-1:0][TMR_W-1:0] cmp_val,
  input logic [SR_W-1:0]               set_en,
  input logic [PORT_W-1:0]             ct_en,
  input logic [PORT_W-1:0]             port_o,
  input logic [TGL_W-1:0]              tgl_q,
  input logic [NUM_CMP-1:0]            flag_o
);
  logic [NUM_CMP-1:0] hit_c;
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_h
    assign hit_c[i] = tick_i && (timer_i == cmp_val[i]);

    // R2
    flag_after_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_c[i] |=> ##1 flag_o[i]);

    // R1
    flag_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(hit_c[i], 2));
  end

  // R3
  set_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_c[CH_SET] && !hit_c[CH_CLR]) |=>
      ((port_o[SR_W-1:0] & $past(set_en)) == $past(set_en)));

  // R8
  clr_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c[CH_CLR] |=> ((port_o[SR_W-1:0] & $past(ct_en[SR_W-1:0])) == '0));

  for (genvar k = 0; k < TGL_W; k++) begin : g_t
    // R5
    tgl_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_c[CH_TGL] && ct_en[SR_W+k]) |=>
        (port_o[SR_W+k] == $past(tgl_q[k])) && (tgl_q[k] != $past(tgl_q[k])));
  end

  // R11
  tgl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_c[CH_TGL] |=> $stable(tgl_q));
endmodule

bind cmp_port_unit cmp_port_chk #(.TMR_W(TMR_W), .PORT_W(PORT_W), .TGL_W(TGL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .timer_i (timer_i),
  .cmp_val (cmp_val),
  .set_en  (set_en),
  .ct_en   (ct_en),
  .port_o  (port_o),
  .tgl_q   (tgl_q),
  .flag_o  (flag_o)
);

// File: tb/sim_cmp_port_unit.sv
module sim_cmp_port_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] timer = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  port;
  logic [2:0]  flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_port_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .timer_i(timer),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .port_o(port), .flag_o(flag)
  );

  // {timer, expected port, expected flags}
  localparam int NV = 7;
  localparam logic [26:0] VEC [NV] = '{
    {16'h0005, 8'h00, 3'b000},
    {16'h0010, 8'h0F, 3'b001},
    {16'h0020, 8'h0C, 3'b010},
    {16'h0030, 8'hCC, 3'b100},
    {16'h0030, 8'h0C, 3'b100},
    {16'h0011, 8'h0C, 3'b000},
    {16'h0010, 8'h0F, 3'b001}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(logic [15:0] t);
    @(negedge clk); tick = 1'b1; timer = t;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 / R6 reset state
    chk("R7 port", 16'(port), 16'h0000);
    chk("R7 flag", 16'(flag), 16'h0000);
    rd(3'd0, d); chk("R7 cmp0", d, 16'h0000);
    rd(3'd4, d); chk("R7 ct_en", d, 16'h0000);
    rd(3'd3, d); chk("R6 tgl reset", d, 16'h00C0);

    wr(3'd0, 16'h0010); wr(3'd1, 16'h0020); wr(3'd2, 16'h0030);
    wr(3'd3, 16'h000F); wr(3'd4, 16'h00C3);

    // table walk: R3 R4 R5 R2
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][26:11]);
      @(negedge clk);
      chk("R3/R4/R5 table port", 16'(port), 16'(VEC[i][10:3]));
      chk("R2 table flag", 16'(flag), 16'(VEC[i][2:0]));
      wr(3'd6, 16'h0007);
    end

    // R1: equal timer without tick does nothing
    wr(3'd5, 16'h0000);
    @(negedge clk); timer = 16'h0010; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no tick port", 16'(port), 16'h0000);
    chk("R1 no tick flag", 16'(flag), 16'h0000);

    // R10 / R2 exact timing
    @(negedge clk); tick = 1'b1; timer = 16'h0010;
    #1 chk("R10 before edge", 16'(port), 16'h0000);
    @(negedge clk); tick = 1'b0;
    chk("R10 port one edge later", 16'(port), 16'h000F);
    chk("R2 flag not yet", 16'(flag), 16'h0000);
    @(negedge clk);
    chk("R2 flag second edge", 16'(flag), 16'h0001);
    rd(3'd6, d); chk("R2 flag readback", d, 16'h0001);
    wr(3'd6, 16'h0001);
    chk("R2 flag cleared", 16'(flag), 16'h0000);

    // R10 software write visible after one edge
    @(negedge clk); we = 1'b1; addr = 3'd5; wdata = 16'h0033;
    @(negedge clk); we = 1'b0;
    chk("R10 sw write", 16'(port), 16'h0033);

    // R8 set and clear together
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0040); wr(3'd1, 16'h0040);
    wr(3'd3, 16'h000F); wr(3'd4, 16'h0003);
    pulse(16'h0040);
    chk("R8 clear beats set", 16'(port), 16'h000C);

    // R9 hardware beats same-cycle software write
    wr(3'd1, 16'h0050);
    @(negedge clk); we = 1'b1; addr = 3'd5; wdata = 16'h00FF;
    tick = 1'b1; timer = 16'h0050;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    chk("R9 hw wins", 16'(port), 16'h00FC);

    // R6 writes to toggle-state bits ignored
    wr(3'd3, 16'h0000);
    rd(3'd3, d); chk("R6 tgl write ignored", d, 16'h00C0);

    // R11 software port write does not move toggle state
    wr(3'd4, 16'h0040); wr(3'd2, 16'h0060);
    wr(3'd5, 16'h0000);
    pulse(16'h0060);
    chk("R5 first toggle sets", 16'(port), 16'h0040);
    wr(3'd5, 16'h0040);
    rd(3'd3, d); chk("R11 tgl after sw write", d, 16'h0080);
    wr(3'd5, 16'h0000);
    pulse(16'h0060);
    chk("R11 toggle uses state not latch", 16'(port), 16'h0000);
    rd(3'd3, d); chk("R5 bit7 untouched", d, 16'h00C0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule